// File: doc/BRIEF.md
# Serial Trace Byte Output Port

A debug trace port that software can only write to. A register bus writes a byte into the port. The port then sends that byte on two pins: a serial clock that the port generates itself, and a data line. The bus is also used to program the port. Software sets whether the port is enabled, which serial clock edge moves the data, how much the system clock is divided by, and how many idle serial-clock periods follow each byte.

A data write is accepted straight away when the port is idle. If a byte, or the gap after it, is still going out, the bus is stalled until the port is free. Software can therefore stream trace bytes back to back without polling. The time it waits grows with both the divisor and the gap setting. Control writes are never stalled. The clock edge, divisor and gap are captured when each byte starts, so a control write made during a byte only takes effect from the next byte. The one exception is clearing the enable, which takes effect at once.

Top module: `trace_port_tx`

## Requirements
- R1: Asynchronous active-low reset does the following:
  - it clears the control register, which disables the port;
  - it drives the serial clock high and the data line low;
  - it leaves ready high.
- R2: The bus has two registers.
  - The data register is at offset 0x0. Reading it returns the last byte written.
  - The control register is at offset 0x4. Reading it returns the 7 stored bits, with bit 7 read as 0.
  - Writes to any other offset are ignored, and reads of any other offset return 0.
- R3: Control bit 0 is the enable. While it is 0 the serial clock stays high and the data line stays low. Clearing it while a byte is being sent stops that byte within one cycle.
- R4: Control bits 3:2 set the serial period N in system clocks: 0 gives N=2, 1 gives N=4, 2 gives N=8, and 3 gives N=2. The clock is low for the first N/2 cycles of each bit slot and high for the last N/2.
- R5: Each byte is sent as 8 bit slots, least-significant bit first. A receiver that samples the data line on each rising edge of the serial clock recovers the byte.
- R6: Control bit 1 selects the edge on which the data line changes.
  - When bit 1 is 1, the data changes on the falling edge at the start of a slot, so at that edge the line already carries the bit of the new slot.
  - When bit 1 is 0, the data changes on the rising edge in the middle of a slot, so at the falling edge the line still carries the previous bit (0 for bit 0).
- R7: Control bits 6:4 hold a value g. After each byte the serial clock idles high for g+1 serial periods before the next byte can start.
- R8: A data write made while a byte or its gap is in progress holds ready low.
  - When the write comes in the cycle after the previous byte was accepted, ready stays low for exactly (8+g+1)*N cycles.
  - Control writes are never held off.
- R9: A data write made while the port is disabled updates the data register without stalling and starts no transfer.
- R10: Between transfers the serial clock idles high and the data line idles low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Bus request valid |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Byte offset of the register |
| req_wdata_i | input | 8 | Write data |
| req_ready_o | output | 1 | Request accepted in this cycle |
| rdata_o | output | 8 | Read data for req_addr_i |
| sclk_o | output | 1 | Generated serial clock |
| sdata_o | output | 1 | Serial data line |

## Verification
The bench drives several control settings, including the reserved divisor code, back to back. For each setting it decodes the byte from the pins and compares the data line at both clock edges.
- A design that shifts most-significant bit first, or launches on the wrong edge, shows up as a wrong rising-edge byte or a wrong falling-edge pattern.
- A design that counts the gap one period short, or ignores the divisor, shows up as a wrong stall length on a second data write.

Directed tests cover the following cases:
- Clearing the enable in the middle of a byte: a design that lets the byte finish keeps toggling the clock.
- A data write while disabled: a design that still sends it toggles the clock.
- An unmapped write: a design that aliases addresses corrupts a register.
- Reset in the middle of a byte.

// File: rtl/tport_pkg.sv
package tport_pkg;
  localparam int GAP_W        = 3;
  localparam int HALF_LOG_MAX = 2;  // largest half-period is 2**2 clocks

  typedef struct packed {
    logic [GAP_W-1:0] gap;
    logic [1:0]       div;
    logic             fall;
    logic             en;
  } tport_ctrl_t;

  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_GAP} tport_state_t;

  // divisor code -> log2 of half serial period; code 3 aliases divide-by-2
  function automatic logic [1:0] div_half_log(input logic [1:0] code);
    case (code)
      2'd1:    return 2'd1;
      2'd2:    return 2'd2;
      default: return 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/tport_regs.sv
module tport_regs
  import tport_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_OFS = 0,
  parameter int CTRL_OFS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic              hit_data_o,
  output tport_ctrl_t       ctrl_o,
  output logic [7:0]        data_o,
  output logic [7:0]        rdata_o
);
  localparam int CTRL_W = $bits(tport_ctrl_t);

  logic        hit_ctrl;
  logic        data_we;
  tport_ctrl_t ctrl_q;
  logic [7:0]  data_q;

  assign hit_data_o = (addr_i == ADDR_W'(DATA_OFS));
  assign hit_ctrl   = (addr_i == ADDR_W'(CTRL_OFS));
  assign data_we    = wr_en_i && hit_data_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      data_q <= '0;
    end else begin
      if (wr_en_i && hit_ctrl) ctrl_q <= tport_ctrl_t'(wdata_i[CTRL_W-1:0]);
      if (data_we)             data_q <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (hit_data_o)    rdata_o = data_q;
    else if (hit_ctrl) rdata_o = 8'(ctrl_q);
  end

  assign ctrl_o = ctrl_q;
  assign data_o = data_q;

  a_r2_data_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_we |=> $stable(data_q));
endmodule

// File: rtl/tport_slot_timer.sv
module tport_slot_timer
  import tport_pkg::*;
#(
  parameter int HALF_LOG_W = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  run_i,
  input  logic [HALF_LOG_W-1:0] half_log_i,
  output logic                  high_o,
  output logic                  last_o
);
  localparam int CNT_W = HALF_LOG_MAX + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] half;

  assign half   = CNT_W'(1) << half_log_i;
  assign high_o = (cnt_q >= half);
  assign last_o = (cnt_q == CNT_W'((2 * half) - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (last_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  a_r4_restart_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && last_o) |=> !high_o);
endmodule

// File: rtl/tport_engine.sv
module tport_engine
  import tport_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              start_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              fall_i,
  input  logic [1:0]        div_i,
  input  logic [GAP_W-1:0]  gap_i,
  output logic              busy_o,
  output logic              sclk_o,
  output logic              sdata_o
);
  localparam int IDX_W = $clog2(BYTE_W);

  tport_state_t      state_q;
  logic [BYTE_W-1:0] sreg_q;
  logic [IDX_W-1:0]  idx_q;
  logic [GAP_W-1:0]  gap_q;
  logic              fall_q;
  logic [1:0]        hlog_q;
  logic              slot_high, slot_last;

  tport_slot_timer #(.HALF_LOG_W(2)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (state_q != ST_IDLE),
    .half_log_i (hlog_q),
    .high_o     (slot_high),
    .last_o     (slot_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sreg_q  <= '0;
      idx_q   <= '0;
      gap_q   <= '0;
      fall_q  <= 1'b0;
      hlog_q  <= '0;
    end else if (!en_i) begin
      state_q <= ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_SHIFT;
          sreg_q  <= byte_i;
          idx_q   <= '0;
          fall_q  <= fall_i;
          hlog_q  <= div_half_log(div_i);
          gap_q   <= gap_i;
        end
        ST_SHIFT: if (slot_last) begin
          if (idx_q == IDX_W'(BYTE_W - 1)) state_q <= ST_GAP;
          else                             idx_q   <= idx_q + 1'b1;
        end
        ST_GAP: if (slot_last) begin
          if (gap_q == '0) state_q <= ST_IDLE;
          else             gap_q   <= gap_q - 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // rising-edge launch: the low half of a slot still carries the previous bit
  always_comb begin
    sdata_o = 1'b0;
    if (state_q == ST_SHIFT) begin
      if (fall_q || slot_high) sdata_o = sreg_q[idx_q];
      else if (idx_q != '0)    sdata_o = sreg_q[idx_q - 1'b1];
    end
  end

  assign sclk_o = (state_q == ST_SHIFT) ? slot_high : 1'b1;
  assign busy_o = (state_q != ST_IDLE);

  a_r8_start_only_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> (state_q == ST_IDLE));
  a_r3_disable_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (sclk_o && !sdata_o));
  a_r5_bit_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && state_q == ST_SHIFT && slot_last && idx_q != IDX_W'(BYTE_W - 1))
    |=> (idx_q == IDX_W'($past(idx_q) + 1'b1)));
  a_r7_gap_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && state_q == ST_SHIFT && slot_last && idx_q == IDX_W'(BYTE_W - 1))
    |=> (state_q == ST_GAP));
endmodule

// File: rtl/trace_port_tx.sv
module trace_port_tx
  import tport_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_OFS = 0,
  parameter int CTRL_OFS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [7:0]        req_wdata_i,
  output logic              req_ready_o,
  output logic [7:0]        rdata_o,
  output logic              sclk_o,
  output logic              sdata_o
);
  tport_ctrl_t ctrl;
  logic [7:0]  data_unused;
  logic        hit_data, busy, wr_acc;

  // only data writes wait on the engine
  assign req_ready_o = !(req_valid_i && req_write_i && hit_data && busy);
  assign wr_acc      = req_valid_i && req_write_i && req_ready_o;

  tport_regs #(.ADDR_W(ADDR_W), .DATA_OFS(DATA_OFS), .CTRL_OFS(CTRL_OFS)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_acc),
    .addr_i     (req_addr_i),
    .wdata_i    (req_wdata_i),
    .hit_data_o (hit_data),
    .ctrl_o     (ctrl),
    .data_o     (data_unused),
    .rdata_o    (rdata_o)
  );

  tport_engine #(.BYTE_W(8)) u_engine (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (ctrl.en),
    .start_i (wr_acc && hit_data && ctrl.en),
    .byte_i  (req_wdata_i),
    .fall_i  (ctrl.fall),
    .div_i   (ctrl.div),
    .gap_i   (ctrl.gap),
    .busy_o  (busy),
    .sclk_o  (sclk_o),
    .sdata_o (sdata_o)
  );

  a_r9_disabled_stays_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl.en |=> !busy);
endmodule

// File: tb/test_trace_port_tx.sv
module test_trace_port_tx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid = 1'b0, write = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       ready, sclk, sdata;
  logic [7:0] rdata;

  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  trace_port_tx i_trace_port_tx (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_write_i(write),
    .req_addr_i(addr), .req_wdata_i(wdata), .req_ready_o(ready),
    .rdata_o(rdata), .sclk_o(sclk), .sdata_o(sdata)
  );

  // pin monitor: decodes bytes at rising edges, records data at falling edges
  logic [7:0] rx_rise [0:63];
  logic [7:0] rx_fall [0:63];
  int         rx_low  [0:63];
  int         rx_n = 0, mon_bit = 0, cur_low = 0, tot_low = 0;
  logic [7:0] rise_acc = '0, fall_acc = '0;
  logic       prev_sclk = 1'b1, mon_clr = 1'b0;

  always @(negedge clk) begin
    if (!rst_n || mon_clr) begin
      mon_bit = 0; cur_low = 0; prev_sclk = 1'b1;
    end else begin
      if (!sclk) begin cur_low++; tot_low++; end
      if (prev_sclk && !sclk) fall_acc[mon_bit] = sdata;
      if (!prev_sclk && sclk) begin
        rise_acc[mon_bit] = sdata;
        mon_bit++;
        if (mon_bit == 8) begin
          if (rx_n < 64) begin
            rx_rise[rx_n] = rise_acc; rx_fall[rx_n] = fall_acc; rx_low[rx_n] = cur_low;
            rx_n++;
          end
          mon_bit = 0; cur_low = 0;
        end
      end
      prev_sclk = sclk;
    end
  end

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [7:0] d, output int stall);
    @(negedge clk);
    valid = 1'b1; write = 1'b1; addr = a; wdata = d;
    stall = 0;
    #1;
    while (!ready) begin stall++; @(negedge clk); #1; end
    @(posedge clk); #1;
    valid = 1'b0; write = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    valid = 1'b1; write = 1'b0; addr = a;
    #1 d = rdata;
    @(posedge clk); #1;
    valid = 1'b0;
  endtask

  function automatic int div_n(input logic [6:0] c);
    case (c[3:2]) 2'd1: return 4; 2'd2: return 8; default: return 2; endcase
  endfunction

  // {ctrl[6:0], byte}
  localparam logic [14:0] VEC [0:5] = '{
    {7'h01, 8'hA5}, {7'h03, 8'h3C}, {7'h25, 8'h81},
    {7'h7B, 8'h5A}, {7'h4D, 8'hF0}, {7'h17, 8'h01}
  };

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    int st, n0, l0;
    repeat (3) @(negedge clk);
    // R1 reset state
    #1;
    check(sclk === 1'b1 && sdata === 1'b0, "R1 pins", {sclk, sdata}, 2'b10);
    check(ready === 1'b1, "R1 ready", ready, 1);
    rst_n = 1'b1;
    bus_read(4'h4, rd);
    check(rd === 8'h00, "R1 ctrl cleared", rd, 0);
    check(sclk === 1'b1 && sdata === 1'b0, "R10 idle", {sclk, sdata}, 2'b10);

    for (int i = 0; i < 6; i++) begin
      logic [6:0] c; logic [7:0] b; int n, g, base;
      c = VEC[i][14:8]; b = VEC[i][7:0];
      n = div_n(c); g = int'(c[6:4]) + 1;
      bus_write(4'h4, {1'b0, c}, st);
      bus_read(4'h4, rd);
      check(rd === {1'b0, c}, "R2 ctrl readback", rd, {1'b0, c});
      base = rx_n;
      bus_write(4'h0, b, st);
      check(st == 0, "R8 idle write not held", st, 0);
      bus_write(4'h0, ~b, st);
      check(st == (8 + g) * n, "R7 R8 hold-off length", st, (8 + g) * n);
      repeat ((8 + g) * n + 4) @(negedge clk);
      check(rx_n == base + 2, "R5 byte count", rx_n, base + 2);
      for (int k = 0; k < 2; k++) begin
        logic [7:0] eb;
        eb = (k == 0) ? b : ~b;
        check(rx_rise[base + k] === eb, "R5 lsb-first byte", rx_rise[base + k], eb);
        if (c[1])
          check(rx_fall[base + k] === eb, "R6 falling launch", rx_fall[base + k], eb);
        else
          check(rx_fall[base + k] === {eb[6:0], 1'b0}, "R6 rising launch",
                rx_fall[base + k], {eb[6:0], 1'b0});
        check(rx_low[base + k] == 4 * n, "R4 divisor low time", rx_low[base + k], 4 * n);
      end
      bus_read(4'h0, rd);
      check(rd === ~b, "R2 data readback", rd, ~b);
      check(sclk === 1'b1 && sdata === 1'b0, "R10 idle after byte", {sclk, sdata}, 2'b10);
    end

    // R3: disable in the middle of a byte
    bus_write(4'h4, 8'h05, st);
    bus_write(4'h0, 8'h55, st);
    repeat (6) @(negedge clk);
    bus_write(4'h4, 8'h00, st);
    check(st == 0, "R8 ctrl write not held", st, 0);
    repeat (2) @(negedge clk);
    #1;
    check(sclk === 1'b1 && sdata === 1'b0, "R3 abort quiet", {sclk, sdata}, 2'b10);
    l0 = tot_low;
    repeat (20) @(negedge clk);
    check(tot_low == l0, "R3 no clock while disabled", tot_low, l0);
    mon_clr = 1'b1; @(negedge clk); mon_clr = 1'b0;

    // R9: data write while disabled
    n0 = rx_n; l0 = tot_low;
    bus_write(4'h0, 8'h77, st);
    check(st == 0, "R9 no stall", st, 0);
    repeat (40) @(negedge clk);
    check(rx_n == n0 && tot_low == l0, "R9 no transfer", tot_low - l0, 0);
    bus_read(4'h0, rd);
    check(rd === 8'h77, "R9 data updated", rd, 8'h77);

    // R2: unmapped offset and bit 7 of control
    bus_write(4'h8, 8'hFF, st);
    bus_read(4'h0, rd);
    check(rd === 8'h77, "R2 unmapped write ignored", rd, 8'h77);
    bus_read(4'h8, rd);
    check(rd === 8'h00, "R2 unmapped read zero", rd, 0);
    bus_write(4'h4, 8'hF0, st);
    bus_read(4'h4, rd);
    check(rd === 8'h70, "R2 ctrl bit7 zero", rd, 8'h70);

    // R1: reset during a transfer
    bus_write(4'h4, 8'h09, st);
    bus_write(4'h0, 8'hC3, st);
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(sclk === 1'b1 && sdata === 1'b0 && ready === 1'b1, "R1 reset mid-byte",
          {sclk, sdata, ready}, 3'b101);
    @(negedge clk); rst_n = 1'b1;
    bus_read(4'h4, rd);
    check(rd === 8'h00, "R1 ctrl cleared again", rd, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule